// File: doc/BRIEF.md
# Clock Divider Chain with Watchdog Reset

This block takes a 4.9152 MHz reference clock and produces every slower timing signal a small controller board needs from one binary counter. The taps are single-cycle clock enables in the reference domain: 614.4 kHz for the converter, 307.2 kHz for the processor, 153.6 kHz as an auxiliary rate, 300 Hz as a periodic interrupt, and 150 Hz as the slow tick. A square 75 Hz display clock is taken directly from the top counter bit.

The block also generates the processor's active-low reset. The reset stays low while the power-good input is low, and then for a fixed count of reference cycles after it rises. Once that delay is over, a watchdog counts slow ticks. Software must pull the kick strobe low before the count expires, which takes about 0.1 s. If it does not, the block asserts reset for a fixed number of cycles, releases it, and the watchdog starts counting again from zero.

Each tap is a power-of-two division, so each tap position is a parameter given as a log2. With the defaults, the taps give the rates listed above.

Top module: `clk_chain_wdog`

## Requirements
- R1: `adc_en` is high for one cycle in every 2^ADC_LOG2 (default 8). Counting rising edges since `pwr_ok` rose as n, it is high exactly when n mod 8 = 7.
- R2: `cpu_en` is high exactly when n mod 2^CPU_LOG2 = 2^CPU_LOG2 - 1. `aux_en` is high exactly when n mod 2^AUX_LOG2 = 2^AUX_LOG2 - 1. Each is one cycle wide.
- R3: `irq_pulse` is high for exactly one cycle when n mod 2^IRQ_LOG2 = 2^IRQ_LOG2 - 1.
- R4: `slow_en` is high when n mod 2^SLOW_LOG2 = 2^SLOW_LOG2 - 1. `disp_clk` equals bit DISP_LOG2-1 of n, which makes it a 50 % square wave with a period of 2^DISP_LOG2 cycles.
- R5: While `pwr_ok` is low, `rst_n` and every enable are low and the chain is cleared, without waiting for a clock edge.
- R6: After `pwr_ok` rises, `rst_n` stays low for n < POR_CYCLES and goes high at n = POR_CYCLES.
- R7: Without kicks, the WDOG_LIMIT-th `slow_en` pulse seen while `rst_n` is high makes `rst_n` go low on the next edge. It stays low for exactly WDRST_CYCLES cycles.
- R8: When a watchdog reset ends, the count restarts from zero, so the next expiry takes another WDOG_LIMIT slow ticks.
- R9: A `kick_n` value of 0 sampled at an edge while `rst_n` is high clears the watchdog count. A kick on the same edge as the expiring slow tick prevents the reset.
- R10: While `rst_n` is low, slow ticks are not counted and kicks have no effect. A kick during a watchdog reset does not shorten that reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 4.9152 MHz reference clock |
| pwr_ok | input | 1 | Supply stable; low clears the block asynchronously |
| kick_n | input | 1 | Active-low watchdog service strobe |
| adc_en | output | 1 | 614.4 kHz converter enable |
| cpu_en | output | 1 | 307.2 kHz processor enable |
| aux_en | output | 1 | 153.6 kHz auxiliary enable |
| irq_pulse | output | 1 | 300 Hz periodic interrupt pulse |
| slow_en | output | 1 | 150 Hz slow tick |
| disp_clk | output | 1 | 75 Hz square display clock |
| rst_n | output | 1 | Active-low processor reset |

## Verification
The bench places the watchdog expiry edge, and the edge where reset is released, down to the exact cycle. A design that is off by one slow tick, or that counts the reset length one cycle short, misses these edges. A kick sampled on the same edge as the expiring tick must win; a design that gives the tick priority would reset a processor that serviced the watchdog in time. Kicks during power-on and during a watchdog reset must do nothing, since a design that lets them act would shorten the reset. Each tap is compared against its exact phase on every cycle, which catches a wrong tap bit or a chain that holds while reset is low.

// File: rtl/clk_chain_wdog.sv
module clk_chain_wdog #(
  parameter int ADC_LOG2     = 3,
  parameter int CPU_LOG2     = 4,
  parameter int AUX_LOG2     = 5,
  parameter int IRQ_LOG2     = 14,
  parameter int SLOW_LOG2    = 15,
  parameter int DISP_LOG2    = 16,
  parameter int WDOG_LIMIT   = 16,
  parameter int POR_CYCLES   = 49152,
  parameter int WDRST_CYCLES = 256
) (
  input  logic clk,
  input  logic pwr_ok,
  input  logic kick_n,
  output logic adc_en,
  output logic cpu_en,
  output logic aux_en,
  output logic irq_pulse,
  output logic slow_en,
  output logic disp_clk,
  output logic rst_n
);
  localparam int CW = DISP_LOG2;
  localparam int WW = $clog2(WDOG_LIMIT + 1);
  localparam int PW = $clog2(POR_CYCLES + 1);
  localparam int RW = $clog2(WDRST_CYCLES + 1);
  localparam logic [WW-1:0] WD_LAST = WW'(WDOG_LIMIT - 1);
  localparam logic [PW-1:0] POR_END = PW'(POR_CYCLES);
  localparam logic [RW-1:0] WDR_LEN = RW'(WDRST_CYCLES);

  logic [CW-1:0] chain;
  logic [PW-1:0] por_cnt;
  logic [WW-1:0] wd_cnt;
  logic [RW-1:0] wdr_cnt;
  logic          por_done, bite;

  always_ff @(posedge clk or negedge pwr_ok)
    if (!pwr_ok) chain <= '0;
    else         chain <= chain + 1'b1;

  assign adc_en    = pwr_ok & (&chain[ADC_LOG2-1:0]);
  assign cpu_en    = pwr_ok & (&chain[CPU_LOG2-1:0]);
  assign aux_en    = pwr_ok & (&chain[AUX_LOG2-1:0]);
  assign irq_pulse = pwr_ok & (&chain[IRQ_LOG2-1:0]);
  assign slow_en   = pwr_ok & (&chain[SLOW_LOG2-1:0]);
  assign disp_clk  = chain[CW-1];

  always_ff @(posedge clk or negedge pwr_ok)
    if (!pwr_ok)              por_cnt <= '0;
    else if (por_cnt != POR_END) por_cnt <= por_cnt + 1'b1;

  assign por_done = (por_cnt == POR_END);
  assign rst_n    = pwr_ok & por_done & (wdr_cnt == '0);
  assign bite     = rst_n & kick_n & slow_en & (wd_cnt == WD_LAST);

  always_ff @(posedge clk or negedge pwr_ok)
    if (!pwr_ok)                     wd_cnt <= '0;
    else if (!rst_n || !kick_n || bite) wd_cnt <= '0;
    else if (slow_en)                wd_cnt <= wd_cnt + 1'b1;

  always_ff @(posedge clk or negedge pwr_ok)
    if (!pwr_ok)             wdr_cnt <= '0;
    else if (bite)           wdr_cnt <= WDR_LEN;
    else if (wdr_cnt != '0)  wdr_cnt <= wdr_cnt - 1'b1;

  AST_ADC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!pwr_ok) adc_en |=> !adc_en); // R1
  AST_CPU_NESTS:     assert property (@(posedge clk) disable iff (!pwr_ok) cpu_en |-> adc_en && aux_en == (&chain[AUX_LOG2-1:0])); // R2
  AST_IRQ_NESTS:     assert property (@(posedge clk) disable iff (!pwr_ok) irq_pulse |-> aux_en && cpu_en); // R3
  AST_DISP_ON_SLOW:  assert property (@(posedge clk) disable iff (!pwr_ok) (disp_clk != $past(disp_clk)) |-> $past(slow_en)); // R4
  AST_POR_HOLDS:     assert property (@(posedge clk) disable iff (!pwr_ok) !por_done |-> !rst_n); // R6
  AST_WDR_LASTS:     assert property (@(posedge clk) disable iff (!pwr_ok) bite |=> !rst_n && wd_cnt == '0); // R7
  AST_WD_BOUND:      assert property (@(posedge clk) disable iff (!pwr_ok) wd_cnt <= WD_LAST); // R8
  AST_KICK_CLEARS:   assert property (@(posedge clk) disable iff (!pwr_ok) (!kick_n && rst_n) |=> wd_cnt == '0 && rst_n); // R9
  AST_RST_FREEZES:   assert property (@(posedge clk) disable iff (!pwr_ok) !rst_n |=> wd_cnt == '0); // R10
endmodule

// File: tb/sim_clk_chain_wdog.sv
module sim_clk_chain_wdog;
  localparam int CLK_T = 10;
  localparam int POR = 20, WDR = 10;

  logic clk = 0, pwr_ok = 0, kick_n = 1;
  logic adc_en, cpu_en, aux_en, irq_pulse, slow_en, disp_clk, rst_n;
  int n = 0, checks = 0, fails = 0;
  int e_adc = 0, e_cpu = 0, e_aux = 0, e_irq = 0, e_slow = 0, e_disp = 0;
  int p_adc = 0, p_irq = 0, kick_run_err = 0;
  bit track_kick_run = 0;

  clk_chain_wdog #(.ADC_LOG2(3), .CPU_LOG2(4), .AUX_LOG2(5), .IRQ_LOG2(7),
    .SLOW_LOG2(8), .DISP_LOG2(9), .WDOG_LIMIT(4), .POR_CYCLES(POR),
    .WDRST_CYCLES(WDR)) u0 (.*);

  always #(CLK_T/2) clk = ~clk;

  always @(posedge clk) if (pwr_ok) n = n + 1; else n = 0;

  always @(negedge clk) if (pwr_ok) begin
    if (adc_en    !== ((n % 8)   == 7))   e_adc++;
    if (cpu_en    !== ((n % 16)  == 15))  e_cpu++;
    if (aux_en    !== ((n % 32)  == 31))  e_aux++;
    if (irq_pulse !== ((n % 128) == 127)) e_irq++;
    if (slow_en   !== ((n % 256) == 255)) e_slow++;
    if (disp_clk  !== 1'((n >> 8) & 1))   e_disp++;
    if (adc_en) p_adc++;
    if (irq_pulse) p_irq++;
    if (track_kick_run && n >= POR && rst_n !== 1'b1) kick_run_err++;
  end

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d (n=%0d)", req, got, exp, n);
    end
  endtask

  task automatic to_n(int target);
    while (n != target) @(negedge clk);
  endtask

  task automatic kick_at(int target);
    to_n(target);
    kick_n = 0;
    @(negedge clk);
    kick_n = 1;
  endtask

  task automatic power_up;
    @(negedge clk);
    pwr_ok = 0;
    #1;
    check("R5 rst_n low while power bad", rst_n, 0);
    check("R5 enables low while power bad", {adc_en, slow_en, disp_clk}, 0);
    @(negedge clk);
    pwr_ok = 1;
  endtask

  // columns: n, expected rst_n
  localparam int VN = 10;
  localparam int VEC [VN][2] = '{
    '{19, 0}, '{20, 1}, '{1023, 1}, '{1024, 0}, '{1033, 0},
    '{1034, 1}, '{2047, 1}, '{2048, 0}, '{2057, 0}, '{2058, 1}};

  initial begin
    #(CLK_T * 400000);
    fails++; checks++;
    $display("FAIL watchdog: run hung");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    power_up();
    for (int i = 0; i < VN; i++) begin
      to_n(VEC[i][0]);
      check(i < 2 ? "R6 power-on hold" : (i < 6 ? "R7 watchdog expiry" : "R8 restart after bite"),
            rst_n, VEC[i][1]);
    end
    to_n(2300);
    check("R1 adc_en phase", e_adc, 0);
    check("R1 adc_en pulse count", p_adc, 2300 / 8);
    check("R2 cpu_en phase", e_cpu, 0);
    check("R2 aux_en phase", e_aux, 0);
    check("R3 irq_pulse phase", e_irq, 0);
    check("R3 irq_pulse count", p_irq, 2300 / 128);
    check("R4 slow_en phase", e_slow, 0);
    check("R4 disp_clk square", e_disp, 0);

    // kicks during power-on, on the expiring tick, and during a bite
    power_up();
    kick_at(10);
    to_n(19);  check("R10 kick in power-on ignored", rst_n, 0);
    to_n(20);  check("R10 power-on length unchanged", rst_n, 1);
    kick_at(1023);
    check("R9 kick beats expiring tick", rst_n, 1);
    to_n(1100); check("R9 still running after kick", rst_n, 1);
    to_n(2047); check("R9 count cleared by kick", rst_n, 1);
    to_n(2048); check("R9 expiry after cleared count", rst_n, 0);
    kick_at(2050);
    to_n(2057); check("R10 kick in bite ignored", rst_n, 0);
    to_n(2058); check("R10 bite length unchanged", rst_n, 1);

    // regular servicing keeps reset released
    power_up();
    track_kick_run = 1;
    for (int k = 100; k <= 5000; k += 500) kick_at(k);
    to_n(5200);
    track_kick_run = 0;
    check("R9 serviced watchdog never bites", kick_run_err, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule